// File: doc/BRIEF.md
# Software Write Protection Command Gate

This block sits between the byte-load front end and the page program sequencer of a page-programmed nonvolatile memory. It watches every byte-load event (address, data, load strobe). It decides whether each byte is forwarded into the page buffer. When the front end signals that a load period has ended, it decides whether the program cycle that follows may change the array.

The block keeps one protection bit. A fixed three-write command sequence sets the bit. A second three-write sequence clears it. The two sequences share their first two writes and differ only in the data of the third. While the bit is set, each load period has to open with the set sequence, or nothing in that period reaches the array. The sequencer's timer still runs for such a blocked period. The bit has its own reset input, separate from the power-on reset, so that it models a nonvolatile cell that survives a power cycle.

The command addresses and data are parameters. The front end delivers the 150 µs byte window as `period_end_i`. Command writes therefore obey the same timing as page loads.

Top module: `swp_gate`

## Requirements
- R1: While `nv_rst_ni` is low, `prot_o` is 0. `rst_ni` alone never changes `prot_o`.
- R2: While unprotected, each load that is not taken as a command byte appears on `wr_o`/`wr_addr_o`/`wr_data_o` in the cycle after it is sampled.
- R3: The set sequence consists of the first three loads of a period: (CMD_A0, CMD_D0), then (CMD_A1, CMD_D1), then (CMD_A2, SET_D2). It sets `prot_o` in the cycle after the third load. Command bytes are never forwarded.
- R4: While protected, data bytes that follow a set sequence in the same period are forwarded, and the period ends with a `permit_o` pulse.
- R5: While protected, a period that does not open with a set or clear sequence forwards no byte. It ends with a `dummy_o` pulse and no `permit_o`.
- R6: The clear sequence is the same as the set sequence except that the third data is CLR_D2. It clears `prot_o` in the cycle after the third load, and the data bytes that follow in that period are forwarded.
- R7: A byte that breaks the sequence is treated as data, together with every later byte of that period. Data is forwarded only if unprotected. No sequence is recognized later in the same period, and bytes already taken as command bytes stay dropped.
- R8: One cycle after `period_end_i`, exactly one of `permit_o`/`dummy_o` pulses for one cycle if the period had at least one load, and neither pulses otherwise. The sequence matcher restarts at each period end.
- R9: `prot_o` keeps its value across periods and across `rst_ni` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async power-on reset (matcher, outputs) |
| nv_rst_ni | input | 1 | Active-low async reset of the protection bit (shipped state) |
| load_i | input | 1 | Byte-load strobe, one cycle per byte |
| addr_i | input | ADDR_W | Load address |
| data_i | input | DATA_W | Load data |
| period_end_i | input | 1 | Load period has ended; program cycle starts |
| wr_o | output | 1 | Forwarded page byte valid |
| wr_addr_o | output | ADDR_W | Forwarded byte address |
| wr_data_o | output | DATA_W | Forwarded byte data |
| permit_o | output | 1 | Period end: array may be written |
| dummy_o | output | 1 | Period end: timer runs, array unchanged |
| prot_o | output | 1 | Protection state |

## Verification
Plain data periods are run with protection off and on. They show forwarding and its suppression, and whether a period closes with a permit or a dummy pulse. Full set and clear sequences followed by data show the exact cycle in which the protection bit flips, and that the command bytes are absorbed. Sequences broken after one byte show that a later full sequence in the same period is ignored. Protected runs show that this drops every byte, while unprotected runs forward the bytes after the break. Empty periods, power-on reset pulses and a protection-bit reset show the outcome-free period end and the persistence of the bit.

// File: rtl/swp_pkg.sv
package swp_pkg;
  typedef enum logic [2:0] {
    M_IDLE, M_ONE, M_TWO, M_OPEN, M_DATA
  } match_st_e;

  typedef enum logic [1:0] {
    EV_NONE, EV_DATA, EV_SET, EV_CLR
  } load_ev_e;
endpackage

// File: rtl/swp_matcher.sv
module swp_matcher
  import swp_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CMD_A0 = 15'h5555,
  parameter logic [DATA_W-1:0] CMD_D0 = 8'hAA,
  parameter logic [ADDR_W-1:0] CMD_A1 = 15'h2AAA,
  parameter logic [DATA_W-1:0] CMD_D1 = 8'h55,
  parameter logic [ADDR_W-1:0] CMD_A2 = 15'h5555,
  parameter logic [DATA_W-1:0] SET_D2 = 8'hA0,
  parameter logic [DATA_W-1:0] CLR_D2 = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              restart_i,
  output load_ev_e          ev_o,
  output logic              open_o,     // sequence accepted before this load
  output logic              open_nx_o   // sequence accepted including this load
);
  localparam int unsigned NSTEP = 3;
  localparam logic [ADDR_W-1:0] SEQ_A [NSTEP] = '{CMD_A0, CMD_A1, CMD_A2};
  localparam logic [DATA_W-1:0] SEQ_D [NSTEP] = '{CMD_D0, CMD_D1, SET_D2};

  logic [NSTEP-1:0] hit;
  logic             clr_hit;
  match_st_e        st_q, st_mid, st_nx;

  for (genvar i = 0; i < NSTEP; i++) begin : g_hit
    assign hit[i] = (addr_i == SEQ_A[i]) && (data_i == SEQ_D[i]);
  end
  assign clr_hit = (addr_i == CMD_A2) && (data_i == CLR_D2);

  always_comb begin
    st_mid = st_q;
    ev_o   = EV_NONE;
    if (load_i) begin
      unique case (st_q)
        M_IDLE: if (hit[0]) st_mid = M_ONE;
                else begin st_mid = M_DATA; ev_o = EV_DATA; end
        M_ONE:  if (hit[1]) st_mid = M_TWO;
                else begin st_mid = M_DATA; ev_o = EV_DATA; end
        M_TWO:  if (hit[2])       begin st_mid = M_OPEN; ev_o = EV_SET; end
                else if (clr_hit) begin st_mid = M_OPEN; ev_o = EV_CLR; end
                else              begin st_mid = M_DATA; ev_o = EV_DATA; end
        default: ev_o = EV_DATA;
      endcase
    end
    st_nx = restart_i ? M_IDLE : st_mid;
  end

  assign open_o    = (st_q == M_OPEN);
  assign open_nx_o = (st_mid == M_OPEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= M_IDLE;
    else         st_q <= st_nx;
  end
endmodule

// File: rtl/swp_nv_bit.sv
module swp_nv_bit (
  input  logic clk_i,
  input  logic nv_rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // no power-on reset: models a nonvolatile cell
  always_ff @(posedge clk_i or negedge nv_rst_ni) begin
    if (!nv_rst_ni)  q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/swp_out_reg.sv
module swp_out_reg #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              permit_i,
  input  logic              dummy_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              permit_o,
  output logic              dummy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o      <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      permit_o  <= 1'b0;
      dummy_o   <= 1'b0;
    end else begin
      wr_o     <= fwd_i;
      permit_o <= permit_i;
      dummy_o  <= dummy_i;
      if (fwd_i) begin
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/swp_gate.sv
module swp_gate
  import swp_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CMD_A0 = 15'h5555,
  parameter logic [DATA_W-1:0] CMD_D0 = 8'hAA,
  parameter logic [ADDR_W-1:0] CMD_A1 = 15'h2AAA,
  parameter logic [DATA_W-1:0] CMD_D1 = 8'h55,
  parameter logic [ADDR_W-1:0] CMD_A2 = 15'h5555,
  parameter logic [DATA_W-1:0] SET_D2 = 8'hA0,
  parameter logic [DATA_W-1:0] CLR_D2 = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nv_rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              period_end_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              permit_o,
  output logic              dummy_o,
  output logic              prot_o
);
  load_ev_e ev;
  logic     open_q, open_nx, prot_nx, any_q, any_nx, fwd, permit, dummy;

  swp_matcher #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CMD_A0(CMD_A0), .CMD_D0(CMD_D0), .CMD_A1(CMD_A1), .CMD_D1(CMD_D1),
    .CMD_A2(CMD_A2), .SET_D2(SET_D2), .CLR_D2(CLR_D2)
  ) u_match (
    .clk_i, .rst_ni, .load_i, .addr_i, .data_i,
    .restart_i (period_end_i),
    .ev_o      (ev),
    .open_o    (open_q),
    .open_nx_o (open_nx)
  );

  swp_nv_bit u_nv (
    .clk_i, .nv_rst_ni,
    .set_i (ev == EV_SET),
    .clr_i (ev == EV_CLR),
    .q_o   (prot_o)
  );

  assign prot_nx = (ev == EV_SET) ? 1'b1 : (ev == EV_CLR) ? 1'b0 : prot_o;
  assign fwd     = (ev == EV_DATA) && (!prot_o || open_q);
  assign any_nx  = any_q | load_i;
  assign permit  = period_end_i && any_nx && (open_nx || !prot_nx);
  assign dummy   = period_end_i && any_nx && !(open_nx || !prot_nx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) any_q <= 1'b0;
    else         any_q <= period_end_i ? 1'b0 : any_nx;
  end

  swp_out_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk_i, .rst_ni,
    .fwd_i    (fwd),
    .addr_i, .data_i,
    .permit_i (permit),
    .dummy_i  (dummy),
    .wr_o, .wr_addr_o, .wr_data_o, .permit_o, .dummy_o
  );
endmodule

// File: rtl/swp_gate_chk.sv
module swp_gate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic nv_rst_ni,
  input logic load_i,
  input logic period_end_i,
  input logic wr_o,
  input logic permit_o,
  input logic dummy_o,
  input logic prot_o
);
  // R8
  outcome_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(permit_o && dummy_o));

  // R8
  outcome_after_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (permit_o || dummy_o) |-> $past(period_end_i));

  // R2
  wr_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(load_i));

  // R9
  prot_moves_on_load_chk: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !nv_rst_ni)
    !$stable(prot_o) |-> $past(load_i));

  // R1
  always @(posedge clk_i)
    if (!nv_rst_ni) nv_clear_chk: assert (!prot_o);
endmodule

bind swp_gate swp_gate_chk u_chk (
  .clk_i, .rst_ni, .nv_rst_ni, .load_i, .period_end_i,
  .wr_o, .permit_o, .dummy_o, .prot_o
);

// File: tb/sim_swp_gate.sv
module sim_swp_gate;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 15;
  localparam int unsigned DW = 8;
  localparam logic [AW-1:0] A0 = 15'h5555, A1 = 15'h2AAA, A2 = 15'h5555;
  localparam logic [DW-1:0] D0 = 8'hAA, D1 = 8'h55, DS = 8'hA0, DC = 8'h20;
  localparam int OUT_PERMIT = 1, OUT_DUMMY = 2;

  logic clk = 1'b0, rst_ni = 1'b0, nv_rst_ni = 1'b0;
  logic load_i = 1'b0, period_end_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic wr_o, permit_o, dummy_o, prot_o;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;

  int n_chk = 0, n_bad = 0;
  logic [AW+DW-1:0] byte_q[$];
  int               out_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  swp_gate u0 (
    .clk_i(clk), .rst_ni, .nv_rst_ni, .load_i, .addr_i, .data_i,
    .period_end_i, .wr_o, .wr_addr_o, .wr_data_o, .permit_o, .dummy_o, .prot_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one load, pushing the expected forward
  task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit fwd);
    @(negedge clk);
    load_i = 1'b1; addr_i = a; data_i = d;
    if (fwd) byte_q.push_back({a, d});
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic end_period(input int exp_out);
    @(negedge clk);
    period_end_i = 1'b1;
    if (exp_out != 0) out_q.push_back(exp_out);
    @(negedge clk);
    period_end_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic seq(input logic [DW-1:0] third, input bit now_prot, input string req);
    load(A0, D0, 1'b0);
    load(A1, D1, 1'b0);
    load(A2, third, 1'b0);
    check(prot_o == now_prot, req, prot_o, now_prot);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && wr_o) begin
      if (byte_q.size() == 0) check(1'b0, "R2/R5/R7 unexpected byte", {wr_addr_o, wr_data_o}, 0);
      else begin
        logic [AW+DW-1:0] e;
        e = byte_q.pop_front();
        check({wr_addr_o, wr_data_o} == e, "R2/R4/R6 forwarded byte", {wr_addr_o, wr_data_o}, e);
      end
    end
    if (rst_ni && (permit_o || dummy_o)) begin
      int act;
      act = permit_o ? OUT_PERMIT : OUT_DUMMY;
      if (permit_o && dummy_o) act = 3;
      if (out_q.size() == 0) check(1'b0, "R8 unexpected outcome", act, 0);
      else begin
        int e;
        e = out_q.pop_front();
        check(act == e, "R4/R5/R8 period outcome", act, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1; nv_rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(prot_o == 1'b0, "R1 prot after reset", prot_o, 0);
    check({wr_o, permit_o, dummy_o} == 3'b000, "R8 outputs idle after reset",
          {wr_o, permit_o, dummy_o}, 0);

    // R2 unprotected plain data
    load(15'h0040, 8'h11, 1'b1);
    load(15'h0041, 8'h22, 1'b1);
    load(15'h7FFF, 8'hFF, 1'b1);
    end_period(OUT_PERMIT);

    // R8 empty period: no outcome
    end_period(0);

    // R3 set sequence then data in same period (R4)
    seq(DS, 1'b1, "R3 prot set");
    load(15'h0100, 8'h5A, 1'b1);
    load(15'h0101, 8'hA5, 1'b1);
    end_period(OUT_PERMIT);

    // R5 protected, no sequence
    load(15'h0200, 8'h01, 1'b0);
    load(15'h0201, 8'h02, 1'b0);
    end_period(OUT_DUMMY);

    // R9 power-on reset leaves protection
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    check(prot_o == 1'b1, "R9 prot across rst_ni", prot_o, 1);

    // R7 broken sequence while protected, later full sequence ignored
    load(A0, D0, 1'b0);
    load(15'h0300, 8'h33, 1'b0);
    seq(DS, 1'b1, "R7 prot unchanged");
    load(15'h0301, 8'h44, 1'b0);
    end_period(OUT_DUMMY);

    // R4 protected period opened with set sequence
    seq(DS, 1'b1, "R4 prot held");
    load(15'h0400, 8'h77, 1'b1);
    end_period(OUT_PERMIT);

    // R6 clear sequence then data
    seq(DC, 1'b0, "R6 prot cleared");
    load(15'h0500, 8'h88, 1'b1);
    end_period(OUT_PERMIT);

    // R7 unprotected: first command byte absorbed, break byte onward forwarded
    load(A0, D0, 1'b0);
    load(A1, 8'h99, 1'b1);
    load(A2, DS, 1'b1);
    check(prot_o == 1'b0, "R7 no late sequence", prot_o, 0);
    end_period(OUT_PERMIT);

    // R1 nonvolatile reset clears protection
    seq(DS, 1'b1, "R3 prot set again");
    end_period(OUT_PERMIT);
    @(negedge clk); nv_rst_ni = 1'b0;
    @(negedge clk);
    check(prot_o == 1'b0, "R1 nv reset clears", prot_o, 0);
    nv_rst_ni = 1'b1;

    repeat (4) @(negedge clk);
    check(byte_q.size() == 0, "R2 byte queue drained", byte_q.size(), 0);
    check(out_q.size() == 0, "R8 outcome queue drained", out_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule